// File: doc/BRIEF.md
# Sleep and Clock-Gating Controller

This block manages power for a small microcontroller. Software programs two byte-wide registers over a simple read/write bus. The control register holds a sleep-enable flag and a two-bit sleep-mode code. The gating register holds one clock-stop bit for each peripheral. The CPU sends a one-cycle sleep strobe when it executes its sleep operation. If sleep is enabled, the block latches the decoded mode into a state register. That state drives the CPU clock enable and a clock enable for each peripheral.

A wake event returns the block to the active state on the next clock edge. The sleep-enable flag is left as it was, so software must clear it. A gated peripheral only loses its clock enable; it receives no reset. Its internal state is frozen, and it continues from that state once its gate bit is cleared. The block contains no clock cells. The enables are meant for gating cells elsewhere in the chip.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset both registers read 0, the state output is 0 (active), `cpu_clk_en` is 1 and every `periph_clk_en` bit is 1.
- R2: All eight bits of the control register (address 0) are readable and writable storage. Bit 5 is sleep-enable. Bit 6 is the upper mode bit and bit 4 the lower mode bit. The other bits have no effect inside the block.
- R3: In the gating register (address 1), bits 7 to 4 ignore writes and always read 0. Bits 3 to 0 read back what was written.
- R4: A sleep strobe while sleep-enable is 0 is ignored: the state stays active and `cpu_clk_en` stays 1.
- R5: A sleep strobe while sleep-enable is 1 sets the state output on the next edge. The mode code {bit6,bit4} is decoded as 00 → 1 (idle), 01 → 2 (power-down), 10 → 3 (standby) and 11 → 2 (power-down).
- R6: In idle (state 1), `cpu_clk_en` is 0 and `periph_clk_en[i]` equals the inverse of gating bit i.
- R7: In power-down (state 2) and standby (state 3), `cpu_clk_en` is 0 and all peripheral enables are 0, whatever the gating bits hold.
- R8: A wake pulse while asleep returns the state to active on the next edge. The sleep-enable bit keeps its value.
- R9: While the block is active, gating bit i set to 1 drives `periph_clk_en[i]` to 0 and cpu_clk_en stays 1. Bit 3 is Timer/Counter1, bit 2 is Timer/Counter0, bit 1 is the serial interface and bit 0 is the UART. The enable returns when the bit is cleared, with no reset, so a counter clocked by it keeps its value while gated.
- R10: Wake has priority over a sleep strobe in the same cycle. A strobe while already asleep does not change the state, even after the mode field has been rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 1 | Register select: 0 control, 1 gating |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| sleep_req | input | 1 | One-cycle sleep strobe from the CPU |
| wake | input | 1 | Wake event |
| pwr_state | output | 2 | 0 active, 1 idle, 2 power-down, 3 standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 4 | Per-peripheral clock enables, bit i for gating bit i |

## Verification
The hardest case to reach from the ports is a sleep state combined with every gating pattern. The peripheral enables only show the gating bits in idle and must hide them in the deeper modes. The stimulus sweeps sleep-enable, all four mode codes and all sixteen gating patterns. It enters sleep and checks the enables before each wake. Retention is checked by a counter in the bench that advances only on `periph_clk_en[3]`. That counter is compared across a gate-and-ungate cycle.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int DATA_W      = 8;
    localparam int N_PERIPH    = 4;
    localparam int SE_BIT      = 5;
    localparam int MODE_HI_BIT = 6;
    localparam int MODE_LO_BIT = 4;

    typedef enum logic [1:0] {
        PS_ACTIVE  = 2'd0,
        PS_IDLE    = 2'd1,
        PS_PDOWN   = 2'd2,
        PS_STANDBY = 2'd3
    } pwr_state_e;

    // Mode code 11 aliases onto power-down.
    function automatic pwr_state_e decode_mode(input logic [1:0] code);
        pwr_state_e s;
        case (code)
            2'b00:   s = PS_IDLE;
            2'b10:   s = PS_STANDBY;
            default: s = PS_PDOWN;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwr_regs.sv
module pwr_regs
    import pwr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NP = N_PERIPH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sleep_en,
    output logic [1:0]    mode_code,
    output logic [NP-1:0] gate_bits
);

    localparam int RSV_W = DW - NP;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [NP-1:0] gate;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            if (bus_addr == 1'b0) regs_d.ctrl = bus_wdata;
            else                  regs_d.gate = bus_wdata[NP-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        if (bus_addr == 1'b0) bus_rdata = regs_q.ctrl;
        else                  bus_rdata = {{RSV_W{1'b0}}, regs_q.gate};
    end

    assign sleep_en  = regs_q.ctrl[SE_BIT];
    assign mode_code = {regs_q.ctrl[MODE_HI_BIT], regs_q.ctrl[MODE_LO_BIT]};
    assign gate_bits = regs_q.gate;

    // R3: reserved gating bits always read zero
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 1'b1) |-> (bus_rdata[DW-1:NP] == '0));

    // R2: a control write is visible on the next cycle
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 1'b0) |=> (regs_q.ctrl == $past(bus_wdata)));

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake,
    input  logic       sleep_en,
    input  logic [1:0] mode_code,
    output pwr_state_e state
);

    typedef struct packed {
        pwr_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (wake) begin
            fsm_d.st = PS_ACTIVE;
        end else if (fsm_q.st == PS_ACTIVE && sleep_req && sleep_en) begin
            fsm_d.st = decode_mode(mode_code);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: PS_ACTIVE};
        else        fsm_q <= fsm_d;
    end

    assign state = fsm_q.st;

    // R4: strobe without enable is ignored
    a_r4_no_sleep_without_se: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE && sleep_req && !sleep_en) |=> (state == PS_ACTIVE));

    // R8: wake returns to active on the next edge
    a_r8_wake_to_active: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (state == PS_ACTIVE));

    // R10: a sleeping state is only left by wake
    a_r10_hold_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_ACTIVE && !wake) |=> $stable(state));

    // R5: entry lands in a sleep state
    a_r5_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE && sleep_req && sleep_en && !wake) |=> (state != PS_ACTIVE));

endmodule

// File: rtl/pwr_gate.sv
module pwr_gate
    import pwr_pkg::*;
#(
    parameter int NP = N_PERIPH
) (
    input  pwr_state_e    state,
    input  logic [NP-1:0] gate_bits,
    output logic          cpu_clk_en,
    output logic [NP-1:0] periph_clk_en
);

    logic periph_allowed;

    assign cpu_clk_en     = (state == PS_ACTIVE);
    assign periph_allowed = (state == PS_ACTIVE) || (state == PS_IDLE);

    for (genvar i = 0; i < NP; i++) begin : g_periph
        assign periph_clk_en[i] = periph_allowed && !gate_bits[i];
    end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NP = N_PERIPH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          sleep_req,
    input  logic          wake,
    output logic [1:0]    pwr_state,
    output logic          cpu_clk_en,
    output logic [NP-1:0] periph_clk_en
);

    logic          sleep_en;
    logic [1:0]    mode_code;
    logic [NP-1:0] gate_bits;
    pwr_state_e    state;

    pwr_regs #(.DW(DW), .NP(NP)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sleep_en  (sleep_en),
        .mode_code (mode_code),
        .gate_bits (gate_bits)
    );

    pwr_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake      (wake),
        .sleep_en  (sleep_en),
        .mode_code (mode_code),
        .state     (state)
    );

    pwr_gate #(.NP(NP)) i_gate (
        .state         (state),
        .gate_bits     (gate_bits),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en)
    );

    assign pwr_state = state;

    // R7: deep sleep stops every peripheral
    a_r7_deep_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_PDOWN || state == PS_STANDBY) |-> (periph_clk_en == '0 && !cpu_clk_en));

    // R6: idle stops the CPU but honours gating bits
    a_r6_idle_gating: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_IDLE) |-> (!cpu_clk_en && periph_clk_en == ~gate_bits));

    // R9: gating bits take effect while active
    a_r9_active_gating: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE) |-> (cpu_clk_en && periph_clk_en == ~gate_bits));

endmodule

// File: tb/test_pwr_sleep_ctrl.sv
module test_pwr_sleep_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sleep_req = 1'b0;
    logic       wake = 1'b0;
    logic [1:0] pwr_state;
    logic       cpu_clk_en;
    logic [3:0] periph_clk_en;

    int n_vec = 0;
    int n_bad = 0;
    int cnt   = 0;

    always #5 clk = ~clk;

    always @(posedge clk) if (periph_clk_en[3]) cnt <= cnt + 1;

    pwr_sleep_ctrl i_pwr_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
        .wake(wake), .pwr_state(pwr_state), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive after a falling edge, leave one rising edge, return at next falling edge
    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_sleep(input logic with_wake);
        sleep_req = 1'b1; wake = with_wake;
        @(negedge clk);
        sleep_req = 1'b0; wake = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    function automatic int exp_state(input int se, input int code);
        if (se == 0)   return 0;
        if (code == 0) return 1;
        if (code == 2) return 3;
        return 2;
    endfunction

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        bus_addr = 1'b0; #1 check("R1 ctrl", bus_rdata, 0);
        bus_addr = 1'b1; #1 check("R1 gate", bus_rdata, 0);
        check("R1 state", pwr_state, 0);
        check("R1 cpu_en", cpu_clk_en, 1);
        check("R1 periph_en", periph_clk_en, 4'hf);

        // R3 reserved gating bits
        wr(1'b1, 8'hff);
        bus_addr = 1'b1; #1 check("R3 gate ff", bus_rdata, 8'h0f);
        wr(1'b1, 8'ha5);
        bus_addr = 1'b1; #1 check("R3 gate a5", bus_rdata, 8'h05);
        wr(1'b1, 8'h00);

        // sweep: sleep-enable x mode code x gating pattern
        for (int se = 0; se < 2; se++) begin
            for (int code = 0; code < 4; code++) begin
                for (int g = 0; g < 16; g++) begin
                    logic [7:0] cv;
                    int es;
                    cv = 8'((g * 37) & 8'h8f);
                    cv[6] = code[1]; cv[4] = code[0]; cv[5] = se[0];
                    wr(1'b0, cv);
                    wr(1'b1, 8'({4'(g + 3), 4'(g)}));
                    bus_addr = 1'b0; #1 check("R2 ctrl readback", bus_rdata, cv);
                    bus_addr = 1'b1; #1 check("R3 gate readback", bus_rdata, g);
                    // R9 active gating
                    check("R9 active periph_en", periph_clk_en, (~g) & 4'hf);
                    check("R9 active cpu_en", cpu_clk_en, 1);
                    pulse_sleep(1'b0);
                    es = exp_state(se, code);
                    check(se ? "R5 state" : "R4 state", pwr_state, es);
                    check("R4/R6/R7 cpu_en", cpu_clk_en, es == 0);
                    if (es == 1)      check("R6 idle periph_en", periph_clk_en, (~g) & 4'hf);
                    else if (es >= 2) check("R7 deep periph_en", periph_clk_en, 0);
                    pulse_wake();
                    check("R8 state after wake", pwr_state, 0);
                    bus_addr = 1'b0; #1 check("R8 ctrl kept", bus_rdata, cv);
                end
            end
        end

        // R10 wake wins over a simultaneous strobe
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h20);
        pulse_sleep(1'b1);
        check("R10 wake priority", pwr_state, 0);
        // R10 strobe while asleep ignored after mode rewrite
        pulse_sleep(1'b0);
        check("R10 enter idle", pwr_state, 1);
        wr(1'b0, 8'h70);
        pulse_sleep(1'b0);
        check("R10 asleep strobe", pwr_state, 1);
        pulse_wake();
        check("R10 woke", pwr_state, 0);
        wr(1'b0, 8'h00);

        // R9 counter retention across gate and ungate of bit 3
        repeat (5) @(negedge clk);
        wr(1'b1, 8'h08);
        begin
            int c0;
            c0 = cnt;
            repeat (7) @(negedge clk);
            check("R9 counter frozen", cnt, c0);
            wr(1'b1, 8'h00);
            check("R9 counter still frozen", cnt, c0);
            repeat (3) @(negedge clk);
            check("R9 counter resumes", cnt, c0 + 3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule